// File: doc/BRIEF.md
# Saturating CRC Error Tally with Self-Test Stepping

This block keeps a running tally of received multiframes whose CRC-6 check failed, so that a host can read how many damaged multiframes arrived on a framed line interface. The upstream framer gives it a one-cycle strobe at each multiframe boundary, together with a flag that says whether that multiframe failed its check. The tally only runs when two mode inputs are both set: one turns on the CRC procedure and the other selects the extended-superframe framing format.

The tally never wraps. It stops at its ceiling: 255 when it is 8 bits wide, or 1023 when a width-select input adds two upper stages. A clear input holds the tally at zero for as long as it is asserted, and counting resumes from zero once it is released.

A separate 3-bit step counter drives alarm self-test. Each step request advances it by one, and after eight requests it is back at zero. While the step value is non-zero, self-test is active: every multiframe strobe counts as an error, so the tally climbs by one per multiframe until it saturates.

Top module: `crc_err_tally`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) sets count_o and step_o to zero.
- R2: If crc_en or esf_en is low, multiframe strobes never change count_o, whatever crc_err and the step value are.
- R3: With crc_en and esf_en both high, count_o rises by exactly one on the clock edge that samples mf_strobe=1 with crc_err=1. A crc_err pulse without mf_strobe is ignored.
- R4: With wide_mode=0, count_o stops at 255. Further qualifying strobes leave it at 255.
- R5: With wide_mode=1, count_o uses all 10 bits (bits 9:8 are the extra stages) and stops at 1023.
- R6: While wide_mode=0, bits 9:8 of count_o read as zero from the next edge onward, and bits 7:0 are kept.
- R7: While step_o is non-zero, every mf_strobe counts as an error (when R2 allows it), even with crc_err=0.
- R8: While clr_hold is high, count_o is zero from the next edge onward and does not count. After release, counting restarts from zero. clr_hold has priority over any increment.
- R9: step_o advances by one (modulo 8) on each edge that samples sim_step_req=1, and otherwise holds. Eight requests bring it back to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mf_strobe | input | 1 | One-cycle pulse at each received multiframe boundary |
| crc_err | input | 1 | The multiframe marked by mf_strobe failed its CRC-6 check |
| crc_en | input | 1 | CRC procedure enabled |
| esf_en | input | 1 | Extended-superframe format selected |
| wide_mode | input | 1 | 1: 10-bit tally, 0: 8-bit tally |
| clr_hold | input | 1 | Hold the tally at zero while high |
| sim_step_req | input | 1 | Advance the self-test step counter |
| count_o | output | 10 | Error tally |
| step_o | output | 3 | Self-test step value |

## Verification
The count and the step value are both registers that drive the ports directly, so a wrong internal state appears on count_o or step_o at the very next clock edge and stays there until a clear or a reset. The bench runs a behavioural model next to the design and compares both outputs on every cycle. A saturation fault therefore shows up on the first strobe past the ceiling, a gating fault on the first strobe with a mode disabled, and a wrong step wrap on the eighth request.

// File: rtl/crc_tally_pkg.sv
package crc_tally_pkg;

   // One qualified multiframe event leaving the gate stage
   typedef struct packed {
      logic fire;      // the tally should advance by one
      logic forced;    // the event came from self-test, not a real error
   } tally_evt_t;

   localparam int unsigned DEF_BASE_W = 8;
   localparam int unsigned DEF_EXT_W  = 2;
   localparam int unsigned DEF_STEP_W = 3;

endpackage

// File: rtl/crc_tally_step.sv
module crc_tally_step #(
   parameter int unsigned STEP_W = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              adv,
   output logic [STEP_W-1:0] step,
   output logic              sim_active
);

   localparam logic [STEP_W-1:0] ONE = STEP_W'(1);

   generate
      if (STEP_W < 1) begin : g_bad_w
         $error("crc_tally_step: STEP_W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)      step <= '0;
      else if (adv) step <= step + ONE;
   end

   assign sim_active = |step;

   p_step_adv_r9: assert property (@(posedge clk) disable iff (rst)
      adv |=> step == $past(step) + ONE);
   p_step_hold_r9: assert property (@(posedge clk) disable iff (rst)
      !adv |=> $stable(step));

endmodule

// File: rtl/crc_tally_gate.sv
module crc_tally_gate
   import crc_tally_pkg::*;
(
   input  logic       mf_strobe,
   input  logic       crc_err,
   input  logic       crc_en,
   input  logic       esf_en,
   input  logic       sim_active,
   output tally_evt_t evt
);

   logic modes_ok;

   always_comb begin
      modes_ok   = crc_en & esf_en;
      evt.fire   = modes_ok & mf_strobe & (crc_err | sim_active);
      evt.forced = modes_ok & mf_strobe & sim_active & ~crc_err;
   end

endmodule

// File: rtl/crc_tally_sat.sv
module crc_tally_sat #(
   parameter int unsigned BASE_W = 8,
   parameter int unsigned EXT_W  = 2
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    inc,
   input  logic                    wide,
   input  logic                    clr,
   output logic [BASE_W+EXT_W-1:0] cnt
);

   localparam int unsigned CNT_W = BASE_W + EXT_W;
   localparam logic [CNT_W-1:0] NARROW_MAX = CNT_W'({BASE_W{1'b1}});
   localparam logic [CNT_W-1:0] WIDE_MAX   = {CNT_W{1'b1}};

   logic [BASE_W-1:0] low_q;
   logic              low_full;
   logic              at_ceiling;
   logic              step_up;

   generate
      if (BASE_W < 2) begin : g_bad_base
         $error("crc_tally_sat: BASE_W must be at least 2");
      end
   endgenerate

   assign low_full = &low_q;
   assign step_up  = inc & ~at_ceiling & ~clr;

   always_ff @(posedge clk) begin
      if (rst || clr)   low_q <= '0;
      else if (step_up) low_q <= low_q + BASE_W'(1);
   end

   generate
      if (EXT_W > 0) begin : g_ext
         logic [EXT_W-1:0] ext_q;
         always_ff @(posedge clk) begin
            if (rst || clr || !wide)       ext_q <= '0;
            else if (step_up && low_full)  ext_q <= ext_q + EXT_W'(1);
         end
         assign at_ceiling = wide ? (low_full & (&ext_q)) : low_full;
         assign cnt        = {ext_q, low_q};

         p_narrow_upper_r6: assert property (@(posedge clk) disable iff (rst)
            !wide |=> cnt[CNT_W-1:BASE_W] == '0);
         p_sat_wide_r5: assert property (@(posedge clk) disable iff (rst)
            (!clr && wide && cnt == WIDE_MAX) |=> cnt == WIDE_MAX);
      end else begin : g_noext
         assign at_ceiling = low_full;
         assign cnt        = low_q;
      end
   endgenerate

   p_sat_narrow_r4: assert property (@(posedge clk) disable iff (rst)
      (!clr && !wide && cnt == NARROW_MAX) |=> cnt == NARROW_MAX);
   p_clr_zero_r8: assert property (@(posedge clk) disable iff (rst)
      clr |=> cnt == '0);

endmodule

// File: rtl/crc_err_tally.sv
module crc_err_tally
   import crc_tally_pkg::*;
#(
   parameter int unsigned BASE_W = DEF_BASE_W,
   parameter int unsigned EXT_W  = DEF_EXT_W,
   parameter int unsigned STEP_W = DEF_STEP_W
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    mf_strobe,
   input  logic                    crc_err,
   input  logic                    crc_en,
   input  logic                    esf_en,
   input  logic                    wide_mode,
   input  logic                    clr_hold,
   input  logic                    sim_step_req,
   output logic [BASE_W+EXT_W-1:0] count_o,
   output logic [STEP_W-1:0]       step_o
);

   localparam int unsigned CNT_W = BASE_W + EXT_W;

   logic       sim_active;
   tally_evt_t evt;

   crc_tally_step #(.STEP_W(STEP_W)) step_i (
      .clk        (clk),
      .rst        (rst),
      .adv        (sim_step_req),
      .step       (step_o),
      .sim_active (sim_active)
   );

   crc_tally_gate gate_i (
      .mf_strobe  (mf_strobe),
      .crc_err    (crc_err),
      .crc_en     (crc_en),
      .esf_en     (esf_en),
      .sim_active (sim_active),
      .evt        (evt)
   );

   crc_tally_sat #(.BASE_W(BASE_W), .EXT_W(EXT_W)) sat_i (
      .clk  (clk),
      .rst  (rst),
      .inc  (evt.fire),
      .wide (wide_mode),
      .clr  (clr_hold),
      .cnt  (count_o)
   );

   p_reset_zero_r1: assert property (@(posedge clk)
      rst |=> (count_o == '0 && step_o == '0));
   p_modes_off_r2: assert property (@(posedge clk) disable iff (rst)
      (!(crc_en && esf_en) && !clr_hold && wide_mode) |=> $stable(count_o));
   p_single_step_r3: assert property (@(posedge clk) disable iff (rst)
      (!clr_hold && wide_mode) |=> count_o - $past(count_o) <= CNT_W'(1));
   p_sim_counts_r7: assert property (@(posedge clk) disable iff (rst)
      (step_o != '0 && crc_en && esf_en && mf_strobe && !clr_hold
       && wide_mode && !(&count_o)) |=> count_o == $past(count_o) + CNT_W'(1));

endmodule

// File: tb/crc_err_tally_tb_top.sv
module crc_err_tally_tb_top;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       mf_strobe = 1'b0, crc_err = 1'b0, crc_en = 1'b0, esf_en = 1'b0;
   logic       wide_mode = 1'b0, clr_hold = 1'b0, sim_step_req = 1'b0;
   logic [9:0] count_o;
   logic [2:0] step_o;

   int    tests = 0, fails = 0, cycles = 0;
   int    m_cnt = 0, m_step = 0;
   string phase = "R1";
   bit    done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   crc_err_tally dut_i (
      .clk(clk), .rst(rst), .mf_strobe(mf_strobe), .crc_err(crc_err),
      .crc_en(crc_en), .esf_en(esf_en), .wide_mode(wide_mode),
      .clr_hold(clr_hold), .sim_step_req(sim_step_req),
      .count_o(count_o), .step_o(step_o)
   );

   // Behavioural reference: updated on each edge from the sampled inputs
   always @(posedge clk) begin
      int lim;
      bit hit;
      if (rst) begin
         m_cnt = 0; m_step = 0;
      end else begin
         hit = crc_en && esf_en && mf_strobe && (crc_err || m_step != 0);
         lim = wide_mode ? 1023 : 255;
         if (clr_hold) m_cnt = 0;
         else begin
            if (!wide_mode) m_cnt = m_cnt % 256;
            if (hit && m_cnt < lim) m_cnt = m_cnt + 1;
         end
         if (sim_step_req) m_step = (m_step + 1) % 8;
      end
   end

   task automatic check(string req, int act, int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Compare on every clock, away from the edge
   always @(negedge clk) begin
      cycles++;
      if (!done) begin
         check({phase, " count"}, int'(count_o), m_cnt);
         check({phase, " step"},  int'(step_o),  m_step);
      end
      if (cycles > 100000 && !done) begin
         done = 1'b1;
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic drive(bit s, bit e);
      @(posedge clk); #1;
      mf_strobe = s; crc_err = e; sim_step_req = 1'b0;
   endtask

   task automatic step_req();
      @(posedge clk); #1;
      mf_strobe = 1'b0; crc_err = 1'b0; sim_step_req = 1'b1;
   endtask

   task automatic strobes(int n, bit e);
      for (int i = 0; i < n; i++) begin
         drive(1'b1, e);
         drive(1'b0, 1'b0);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst = 1'b0;
      @(negedge clk);
      check("R1 reset count", int'(count_o), 0);
      check("R1 reset step", int'(step_o), 0);

      phase = "R2";
      crc_en = 1'b1; esf_en = 1'b0; wide_mode = 1'b1;
      strobes(5, 1'b1);
      crc_en = 1'b0; esf_en = 1'b1;
      strobes(5, 1'b1);
      @(negedge clk);
      check("R2 modes off", int'(count_o), 0);

      phase = "R3";
      crc_en = 1'b1; esf_en = 1'b1;
      strobes(4, 1'b1);
      strobes(3, 1'b0);
      drive(1'b0, 1'b1);   // error without strobe: ignored
      drive(1'b0, 1'b0);
      @(negedge clk);
      check("R3 error count", int'(count_o), 4);

      phase = "R4";
      wide_mode = 1'b0;
      strobes(270, 1'b1);
      @(negedge clk);
      check("R4 narrow ceiling", int'(count_o), 255);

      phase = "R5";
      wide_mode = 1'b1;
      strobes(780, 1'b1);
      @(negedge clk);
      check("R5 wide ceiling", int'(count_o), 1023);

      phase = "R6";
      wide_mode = 1'b0;
      drive(1'b0, 1'b0);
      drive(1'b0, 1'b0);
      @(negedge clk);
      check("R6 upper stages zero", int'(count_o), 255);

      phase = "R8";
      clr_hold = 1'b1;
      strobes(3, 1'b1);
      @(negedge clk);
      check("R8 held at zero", int'(count_o), 0);
      clr_hold = 1'b0;
      strobes(2, 1'b1);
      @(negedge clk);
      check("R8 restart from zero", int'(count_o), 2);

      phase = "R7";
      step_req();
      drive(1'b0, 1'b0);
      strobes(6, 1'b0);
      @(negedge clk);
      check("R7 step one", int'(step_o), 1);
      check("R7 forced count", int'(count_o), 8);

      phase = "R9";
      for (int i = 0; i < 7; i++) begin
         step_req();
         drive(1'b0, 1'b0);
      end
      @(negedge clk);
      check("R9 wrap to zero", int'(step_o), 0);
      strobes(3, 1'b0);
      @(negedge clk);
      check("R9 sim off after wrap", int'(count_o), 8);

      phase = "R1";
      drive(1'b0, 1'b0);
      rst = 1'b1;
      drive(1'b0, 1'b0);
      rst = 1'b0;
      @(negedge clk);
      check("R1 second reset", int'(count_o), 0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule